// File: doc/BRIEF.md
# Luma/chroma pixel routing network

This block carries one macroblock record through a small chain of FIFO-linked stages. A record is a stream of 256 unsigned pixels: four sub-blocks of 64 pixels each, ordered as two luminance sub-blocks (index 0 and 1) and then two chrominance sub-blocks (index 2 and 3). A source stage counts the incoming pixels. It sends luminance pixels into a FIFO that feeds a pre-shift stage, and it sends chrominance pixels into a bypass FIFO.

A merge stage feeds an external transform through a valid/ready request port. It takes sub-blocks 0 and 1 from the pre-shift FIFO and sub-blocks 2 and 3 from the bypass FIFO, strictly in index order. The transform arithmetic itself lies outside the block. The transform hands its results back through a valid/ready response port into a sink FIFO. The sink labels each result with its sub-block and pixel position, and it pulses a record-done flag once the 256th result has left.

Every stage moves at most one pixel per cycle. A stage moves only when its input FIFO holds data and its output has room. Each FIFO is deep enough to hold one whole sub-block.

Top module: `prn_route_net`

## Requirements
- R1: While reset is applied and after it is released, the block shows in_ready=1, xf_in_valid=0, out_valid=0 and rec_done=0. Internal state is released two rising clock edges after rst_n goes high.
- R2: Input pixels are numbered k=0..255 within a record. Pixel k belongs to sub-block k/64 at position k%64. Every record produces exactly 256 transform request beats and 256 output beats.
- R3: For sub-blocks 0 and 1, xf_in_data is the input pixel minus 128, as a 9-bit two's complement value in the range -128..127.
- R4: For sub-blocks 2 and 3, xf_in_data is the input pixel zero-extended to 9 bits, in the range 0..255. Bit 8 is always 0.
- R5: Request beats leave in input order. A chrominance pixel that is already waiting is never presented while a luminance pixel of the same record is still outstanding.
- R6: While xf_in_valid=1 and xf_in_ready=0, xf_in_valid stays 1 and xf_in_data stays unchanged on the next cycle.
- R7: If the transform never accepts a request, the block takes exactly 192 pixels of a record and then holds in_ready=0. Once the transform resumes, no pixel is lost or reordered.
- R8: Each response beat appears once on out_data, unchanged and in arrival order. out_sub and out_pix count from 0 to 3 and from 0 to 63, and out_pix advances by one after each beat.
- R9: rec_done is a one-cycle pulse in the cycle after the beat with out_sub=3 and out_pix=63. The next beat is labelled sub-block 0, pixel 0.
- R10: Reset applied in the middle of a record discards the partial record. The next record is processed correctly from sub-block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input pixel valid |
| in_pixel | input | PIX_W | Unsigned input pixel |
| in_ready | output | 1 | Block can take the input pixel |
| xf_in_valid | output | 1 | Transform request valid |
| xf_in_data | output | PIX_W+1 | Signed pixel sent to the transform |
| xf_in_ready | input | 1 | Transform takes the request |
| xf_out_valid | input | 1 | Transform response valid |
| xf_out_data | input | RSP_W | Transform result pixel |
| xf_out_ready | output | 1 | Sink FIFO has room |
| out_valid | output | 1 | Collected result valid |
| out_data | output | RSP_W | Collected result pixel |
| out_sub | output | clog2(SUBS) | Sub-block index of the result |
| out_pix | output | clog2(SUB_PIX) | Pixel position within the sub-block |
| rec_done | output | 1 | One-cycle pulse after a full record |

## Verification
Latency is counted from the clock edge that accepts a pixel:
- A chrominance pixel reaches the transform request port one cycle later.
- A luminance pixel reaches it two cycles later, because the pre-shift stage moves it between two FIFOs.
- A response accepted at an edge appears on the output one cycle later.
- rec_done follows the 256th output beat by one further cycle.

All ready and valid outputs depend only on registered state. The bench therefore samples them at the falling edge and decides its own handshakes there, so every transfer it counts completes at the next rising edge. It compares each beat against values it computes from the input pixels. It expects rec_done exactly one falling-edge sample after the last beat. The backpressure case is checked by counting accepted pixels after the pipeline has been idle for thirty cycles.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int unsigned PRN_PIX_W      = 8;
  localparam int unsigned PRN_SUB_PIX    = 64;
  localparam int unsigned PRN_SUBS       = 4;
  localparam int unsigned PRN_LUMA_SUBS  = 2;
  localparam int unsigned PRN_RSP_W      = 12;

  typedef enum logic {
    ROUTE_SHIFT  = 1'b0,
    ROUTE_BYPASS = 1'b1
  } route_e;
endpackage

// File: rtl/prn_fifo.sv
module prn_fifo #(
  parameter int unsigned W     = 9,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CMAX);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end
endmodule

// File: rtl/prn_source.sv
module prn_source
  import prn_pkg::*;
#(
  parameter int unsigned PIX_W     = PRN_PIX_W,
  parameter int unsigned SUB_PIX   = PRN_SUB_PIX,
  parameter int unsigned SUBS      = PRN_SUBS,
  parameter int unsigned LUMA_SUBS = PRN_LUMA_SUBS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             in_ready,
  output logic             luma_push,
  output logic [PIX_W-1:0] luma_data,
  input  logic             luma_full,
  output logic             byp_push,
  output logic [PIX_W:0]   byp_data,
  input  logic             byp_full
);
  localparam int unsigned SW = $clog2(SUBS);
  localparam int unsigned PW = $clog2(SUB_PIX);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(SUB_PIX - 1);

  logic [SW-1:0] sub_q, sub_d;
  logic [PW-1:0] pix_q, pix_d;
  route_e        route;
  logic          fire;

  assign route     = (sub_q < SW'(LUMA_SUBS)) ? ROUTE_SHIFT : ROUTE_BYPASS;
  assign in_ready  = (route == ROUTE_SHIFT) ? ~luma_full : ~byp_full;
  assign fire      = in_valid & in_ready;
  assign luma_push = fire & (route == ROUTE_SHIFT);
  assign byp_push  = fire & (route == ROUTE_BYPASS);
  assign luma_data = in_pixel;
  assign byp_data  = {1'b0, in_pixel};

  always_comb begin
    sub_d = sub_q;
    pix_d = pix_q;
    if (fire) begin
      if (pix_q == PIX_LAST) begin
        pix_d = '0;
        sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end else begin
        pix_d = pix_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      pix_q <= '0;
    end else begin
      sub_q <= sub_d;
      pix_q <= pix_d;
    end
  end
endmodule

// File: rtl/prn_preshift.sv
module prn_preshift #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             src_empty,
  input  logic [PIX_W-1:0] src_data,
  output logic             src_pop,
  input  logic             dst_full,
  output logic             dst_push,
  output logic [PIX_W:0]   dst_data
);
  localparam int unsigned  OFF   = 1 << (PIX_W - 1);
  localparam logic [PIX_W:0] OFF_V = (PIX_W + 1)'(OFF);

  logic move;

  assign move     = ~src_empty & ~dst_full;
  assign src_pop  = move;
  assign dst_push = move;
  assign dst_data = {1'b0, src_data} - OFF_V;
endmodule

// File: rtl/prn_merge.sv
module prn_merge
  import prn_pkg::*;
#(
  parameter int unsigned PIX_W     = PRN_PIX_W,
  parameter int unsigned SUB_PIX   = PRN_SUB_PIX,
  parameter int unsigned SUBS      = PRN_SUBS,
  parameter int unsigned LUMA_SUBS = PRN_LUMA_SUBS,
  localparam int unsigned SW       = $clog2(SUBS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_empty,
  input  logic [PIX_W:0] shift_data,
  output logic           shift_pop,
  input  logic           byp_empty,
  input  logic [PIX_W:0] byp_data,
  output logic           byp_pop,
  output logic           xf_valid,
  output logic [PIX_W:0] xf_data,
  input  logic           xf_ready,
  output logic [SW-1:0]  cur_sub
);
  localparam int unsigned PW = $clog2(SUB_PIX);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(SUB_PIX - 1);

  logic [SW-1:0] sub_q, sub_d;
  logic [PW-1:0] pix_q, pix_d;
  route_e        route;
  logic          fire;

  assign route     = (sub_q < SW'(LUMA_SUBS)) ? ROUTE_SHIFT : ROUTE_BYPASS;
  assign xf_valid  = (route == ROUTE_SHIFT) ? ~shift_empty : ~byp_empty;
  assign xf_data   = (route == ROUTE_SHIFT) ? shift_data : byp_data;
  assign fire      = xf_valid & xf_ready;
  assign shift_pop = fire & (route == ROUTE_SHIFT);
  assign byp_pop   = fire & (route == ROUTE_BYPASS);
  assign cur_sub   = sub_q;

  always_comb begin
    sub_d = sub_q;
    pix_d = pix_q;
    if (fire) begin
      if (pix_q == PIX_LAST) begin
        pix_d = '0;
        sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end else begin
        pix_d = pix_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      pix_q <= '0;
    end else begin
      sub_q <= sub_d;
      pix_q <= pix_d;
    end
  end
endmodule

// File: rtl/prn_route_net.sv
module prn_route_net
  import prn_pkg::*;
#(
  parameter int unsigned PIX_W     = PRN_PIX_W,
  parameter int unsigned SUB_PIX   = PRN_SUB_PIX,
  parameter int unsigned SUBS      = PRN_SUBS,
  parameter int unsigned LUMA_SUBS = PRN_LUMA_SUBS,
  parameter int unsigned RSP_W     = PRN_RSP_W,
  localparam int unsigned SW       = $clog2(SUBS),
  localparam int unsigned PW       = $clog2(SUB_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             in_ready,
  output logic             xf_in_valid,
  output logic [PIX_W:0]   xf_in_data,
  input  logic             xf_in_ready,
  input  logic             xf_out_valid,
  input  logic [RSP_W-1:0] xf_out_data,
  output logic             xf_out_ready,
  output logic             out_valid,
  output logic [RSP_W-1:0] out_data,
  output logic [SW-1:0]    out_sub,
  output logic [PW-1:0]    out_pix,
  output logic             rec_done
);
  localparam int unsigned XW = PIX_W + 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(SUB_PIX - 1);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             lf_push, lf_pop, lf_empty, lf_full;
  logic [PIX_W-1:0] lf_wdata, lf_rdata;
  logic             sf_push, sf_pop, sf_empty, sf_full;
  logic [XW-1:0]    sf_wdata, sf_rdata;
  logic             bf_push, bf_pop, bf_empty, bf_full;
  logic [XW-1:0]    bf_wdata, bf_rdata;
  logic             kf_pop, kf_empty, kf_full;
  logic [SW-1:0]    merge_sub;

  prn_source #(.PIX_W(PIX_W), .SUB_PIX(SUB_PIX), .SUBS(SUBS), .LUMA_SUBS(LUMA_SUBS)) u_source (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(in_valid), .in_pixel(in_pixel), .in_ready(in_ready),
    .luma_push(lf_push), .luma_data(lf_wdata), .luma_full(lf_full),
    .byp_push(bf_push), .byp_data(bf_wdata), .byp_full(bf_full)
  );

  prn_fifo #(.W(PIX_W), .DEPTH(SUB_PIX)) u_luma_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(lf_push), .wdata(lf_wdata),
    .pop(lf_pop), .rdata(lf_rdata), .empty(lf_empty), .full(lf_full)
  );

  prn_preshift #(.PIX_W(PIX_W)) u_preshift (
    .src_empty(lf_empty), .src_data(lf_rdata), .src_pop(lf_pop),
    .dst_full(sf_full), .dst_push(sf_push), .dst_data(sf_wdata)
  );

  prn_fifo #(.W(XW), .DEPTH(SUB_PIX)) u_shift_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(sf_push), .wdata(sf_wdata),
    .pop(sf_pop), .rdata(sf_rdata), .empty(sf_empty), .full(sf_full)
  );

  prn_fifo #(.W(XW), .DEPTH(SUB_PIX)) u_byp_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(bf_push), .wdata(bf_wdata),
    .pop(bf_pop), .rdata(bf_rdata), .empty(bf_empty), .full(bf_full)
  );

  prn_merge #(.PIX_W(PIX_W), .SUB_PIX(SUB_PIX), .SUBS(SUBS), .LUMA_SUBS(LUMA_SUBS)) u_merge (
    .clk(clk), .rst_n(rst_sync_n),
    .shift_empty(sf_empty), .shift_data(sf_rdata), .shift_pop(sf_pop),
    .byp_empty(bf_empty), .byp_data(bf_rdata), .byp_pop(bf_pop),
    .xf_valid(xf_in_valid), .xf_data(xf_in_data), .xf_ready(xf_in_ready),
    .cur_sub(merge_sub)
  );

  // sink: result FIFO drained one beat per cycle, labelled by counters
  assign xf_out_ready = ~kf_full;

  prn_fifo #(.W(RSP_W), .DEPTH(SUB_PIX)) u_sink_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(xf_out_valid), .wdata(xf_out_data),
    .pop(kf_pop), .rdata(out_data), .empty(kf_empty), .full(kf_full)
  );

  logic [SW-1:0] osub_q, osub_d;
  logic [PW-1:0] opix_q, opix_d;
  logic          done_q, done_d;

  assign out_valid = ~kf_empty;
  assign kf_pop    = out_valid;
  assign out_sub   = osub_q;
  assign out_pix   = opix_q;
  assign rec_done  = done_q;

  always_comb begin
    osub_d = osub_q;
    opix_d = opix_q;
    done_d = 1'b0;
    if (out_valid) begin
      if (opix_q == PIX_LAST) begin
        opix_d = '0;
        if (osub_q == SUB_LAST) begin
          osub_d = '0;
          done_d = 1'b1;
        end else begin
          osub_d = osub_q + 1'b1;
        end
      end else begin
        opix_d = opix_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      osub_q <= '0;
      opix_q <= '0;
      done_q <= 1'b0;
    end else begin
      osub_q <= osub_d;
      opix_q <= opix_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/prn_route_chk.sv
module prn_route_chk #(
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned SUB_PIX   = 64,
  parameter int unsigned SUBS      = 4,
  parameter int unsigned LUMA_SUBS = 2,
  localparam int unsigned SW       = $clog2(SUBS),
  localparam int unsigned PW       = $clog2(SUB_PIX)
) (
  input logic           clk,
  input logic           rst_i,
  input logic           xf_in_valid,
  input logic           xf_in_ready,
  input logic [PIX_W:0] xf_in_data,
  input logic [SW-1:0]  merge_sub,
  input logic           out_valid,
  input logic [SW-1:0]  out_sub,
  input logic [PW-1:0]  out_pix,
  input logic           rec_done
);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(SUB_PIX - 1);

  // R6
  xf_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (xf_in_valid && !xf_in_ready) |=> (xf_in_valid && $stable(xf_in_data)));

  // R4
  chroma_range_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (xf_in_valid && (merge_sub >= SW'(LUMA_SUBS))) |-> !xf_in_data[PIX_W]);

  // R8
  out_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |=> (out_pix == (($past(out_pix) == PIX_LAST) ? '0 : $past(out_pix) + 1'b1)));

  // R9
  rec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rec_done |=> !rec_done);

  // R9
  rec_after_last_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rec_done |-> $past(out_valid && (out_sub == SUB_LAST) && (out_pix == PIX_LAST)));
endmodule

bind prn_route_net prn_route_chk #(
  .PIX_W(PIX_W), .SUB_PIX(SUB_PIX), .SUBS(SUBS), .LUMA_SUBS(LUMA_SUBS)
) u_chk (
  .clk(clk), .rst_i(rst_sync_n),
  .xf_in_valid(xf_in_valid), .xf_in_ready(xf_in_ready), .xf_in_data(xf_in_data),
  .merge_sub(merge_sub),
  .out_valid(out_valid), .out_sub(out_sub), .out_pix(out_pix),
  .rec_done(rec_done)
);

// File: tb/tb_prn_route_net.sv
`timescale 1ns/1ps
module tb_prn_route_net;
  localparam int PIX_W = 8;
  localparam int SUB_PIX = 64;
  localparam int SUBS = 4;
  localparam int RSP_W = 12;
  localparam int NPIX = SUB_PIX * SUBS;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [PIX_W-1:0] in_pixel;
  logic in_ready;
  logic xf_in_valid;
  logic [PIX_W:0] xf_in_data;
  logic xf_in_ready;
  logic xf_out_valid;
  logic [RSP_W-1:0] xf_out_data;
  logic xf_out_ready;
  logic out_valid;
  logic [RSP_W-1:0] out_data;
  logic [1:0] out_sub;
  logic [5:0] out_pix;
  logic rec_done;

  always #10 clk = ~clk;

  prn_route_net #(.PIX_W(PIX_W), .SUB_PIX(SUB_PIX), .SUBS(SUBS), .LUMA_SUBS(2), .RSP_W(RSP_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel), .in_ready(in_ready),
    .xf_in_valid(xf_in_valid), .xf_in_data(xf_in_data), .xf_in_ready(xf_in_ready),
    .xf_out_valid(xf_out_valid), .xf_out_data(xf_out_data), .xf_out_ready(xf_out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sub(out_sub), .out_pix(out_pix),
    .rec_done(rec_done)
  );

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  int pix_mem [NPIX];
  bit xf_hold = 1'b0;
  bit gap_mode = 1'b0;
  int drv_idx = 0;
  int xf_idx = 0;
  int recs_done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_xf(input int k);
    return (k / SUB_PIX < 2) ? pix_mem[k] - 128 : pix_mem[k];
  endfunction

  // watchdog and cycle count
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  // transform model: gathers 64 requests, returns them in reverse order
  int xbuf [SUB_PIX];
  int xc = 0;
  int xe = 0;
  bit emitting = 1'b0;
  always @(negedge clk) begin
    xf_out_valid = 1'b0;
    xf_in_ready  = 1'b0;
    if (!rst_n) begin
      xc = 0; xe = 0; emitting = 1'b0; xf_idx = 0;
    end else if (emitting) begin
      if (xf_out_ready && (!gap_mode || (cyc % 4) != 1)) begin
        xf_out_valid = 1'b1;
        xf_out_data  = RSP_W'(xbuf[SUB_PIX-1-xe]);
        xe++;
        if (xe == SUB_PIX) emitting = 1'b0;
      end
    end else if (!xf_hold) begin
      xf_in_ready = 1'b1;
      if (xf_in_valid) begin
        int k;
        k = xf_idx % NPIX;
        check(int'($signed(xf_in_data)) == exp_xf(k), (k / SUB_PIX < 2) ? "R3" : "R4",
              "transform request", int'($signed(xf_in_data)), exp_xf(k));
        xbuf[xc] = int'($signed(xf_in_data));
        xc++;
        xf_idx++;
        if (xc == SUB_PIX) begin emitting = 1'b1; xc = 0; xe = 0; end
      end
    end
  end

  // output monitor
  int oc = 0;
  bit last_flag = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      oc = 0; last_flag = 1'b0;
    end else begin
      if (rec_done || last_flag)
        check(rec_done == last_flag, "R9", "rec_done timing", int'(rec_done), int'(last_flag));
      last_flag = 1'b0;
      if (out_valid) begin
        int s, j;
        s = oc / SUB_PIX;
        j = oc % SUB_PIX;
        check(int'($signed(out_data)) == exp_xf(s * SUB_PIX + SUB_PIX - 1 - j), "R8", "out_data",
              int'($signed(out_data)), exp_xf(s * SUB_PIX + SUB_PIX - 1 - j));
        check((int'(out_sub) == s) && (int'(out_pix) == j), "R8", "out label",
              int'(out_sub) * SUB_PIX + int'(out_pix), oc);
        oc++;
        if (oc == NPIX) begin oc = 0; last_flag = 1'b1; recs_done++; end
      end
    end
  end

  task automatic drive(input int lim, input int stop_idle);
    int idle;
    idle = 0;
    while (drv_idx < lim && idle < stop_idle) begin
      @(negedge clk);
      if (in_ready && !(gap_mode && (cyc % 3) == 2)) begin
        in_valid = 1'b1;
        in_pixel = PIX_W'(pix_mem[drv_idx]);
        drv_idx++;
        idle = 0;
      end else begin
        in_valid = 1'b0;
        idle++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rec(input int target);
    while (recs_done < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < NPIX; i++) begin
      case (mode)
        0: pix_mem[i] = i % 256;
        1: pix_mem[i] = (i % 2) ? 255 : 0;
        2: pix_mem[i] = (i * 73 + 41) % 256;
        default: pix_mem[i] = (i * 29 + 200) % 256;
      endcase
    end
  endtask

  task automatic run_record(input int mode, input string tag);
    int base;
    fill(mode);
    base = xf_idx;
    drv_idx = 0;
    drive(NPIX, 1000);
    wait_rec(recs_done + 1);
    check(xf_idx - base == NPIX, "R2", tag, xf_idx - base, NPIX);
  endtask

  task automatic check_idle(input string req);
    check(in_ready == 1'b1, req, "in_ready idle", int'(in_ready), 1);
    check(xf_in_valid == 1'b0, req, "xf_in_valid idle", int'(xf_in_valid), 0);
    check(out_valid == 1'b0, req, "out_valid idle", int'(out_valid), 0);
    check(rec_done == 1'b0, req, "rec_done idle", int'(rec_done), 0);
  endtask

  initial begin
    int base;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_pixel = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    run_record(0, "ramp record beats");
    gap_mode = 1'b1;
    run_record(1, "extreme record with gaps");
    gap_mode = 1'b0;
    run_record(2, "mixed record beats");

    // R7 / R5: transform stalled, FIFOs fill
    fill(3);
    base = xf_idx;
    drv_idx = 0;
    xf_hold = 1'b1;
    drive(NPIX, 30);
    check(drv_idx == 192, "R7", "pixels taken while stalled", drv_idx, 192);
    check(in_ready == 1'b0, "R7", "in_ready while stalled", int'(in_ready), 0);
    check(xf_in_valid == 1'b1, "R5", "request pending", int'(xf_in_valid), 1);
    check(int'($signed(xf_in_data)) == pix_mem[0] - 128, "R5", "luma presented first",
          int'($signed(xf_in_data)), pix_mem[0] - 128);
    check(out_valid == 1'b0, "R7", "no output while stalled", int'(out_valid), 0);
    xf_hold = 1'b0;
    drive(NPIX, 1000);
    wait_rec(recs_done + 1);
    check(xf_idx - base == NPIX, "R7", "beats after release", xf_idx - base, NPIX);

    // R10: reset in the middle of a record
    fill(2);
    drv_idx = 0;
    drive(100, 1000);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R10");
    run_record(0, "R10 record after mid reset");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule